// File: doc/BRIEF.md
# Dual-Channel Serial Frame Monitor

This block listens, without driving anything, to two asynchronous serial lines: a receive line and a transmit line. It decodes the start/data/parity/stop frames on each line. The two lines have separate decoding engines, so frames may overlap in any way or land on the same cycles. Each engine passes its line through a two-flop synchronizer. It detects a frame when the line falls from high to low. It then samples every bit at its centre, using a clock-cycle counter measured against a programmable clocks-per-bit divisor.

Software-visible configuration is shared by both engines:
- the divisor;
- the data length;
- the parity rule;
- the bit order.

Each engine copies the configuration when it sees a start edge, so a change made during a frame affects only later frames. For every frame the engine reports the assembled data word with a one-cycle valid pulse. It also reports three error flags that stay set until the next start edge: start bit not low, parity mismatch, and stop bit not high. A bad start bit is flagged, but the rest of the frame is still decoded.

Top module: `uart_mon_dual`

## Requirements
- R1: A frame starts only when the synchronized line goes from high to low. A line that is already low when reset ends, and stays low, starts no frame. The first sample after reset only loads the previous-level register.
- R2: Bit k of a frame (k=0 is the start bit) is sampled floor(cpb/2) + k*cpb clock cycles after the detected edge, where cpb = `cfg_clks_per_bit`, which must be at least 4. After reset, every data and flag output is 0.
- R3: `cfg_data_bits` sets the number of data bits. Values 5 to 9 are used as given, values below 5 act as 5, and values above 9 act as 9. Bits of the data output above the data length read 0.
- R4: With `cfg_msb_first`=0, the first data bit on the line becomes bit 0 of the output word. With `cfg_msb_first`=1, the first data bit becomes bit N-1, where N is the data length.
- R5: Parity code 1 (odd) requires the count of ones across the data bits and the parity bit to be odd. Code 2 (even) requires that count to be even. A mismatch sets the parity error flag.
- R6: Parity code 3 requires the parity bit to be 0, and code 4 requires it to be 1. A mismatch sets the parity error flag.
- R7: With parity code 0, no parity bit is present. The stop bit is then the bit directly after the last data bit, and the parity error flag stays 0.
- R8: Parity codes 5, 6 and 7 behave exactly like code 0.
- R9: If the start bit is high at its centre sample, the start error flag is set, and the data bits are still decoded and reported.
- R10: If the single stop bit is low at its centre sample, the stop error flag is set. Decoding then always returns to waiting for a start edge.
- R11: The valid output pulses high for exactly one cycle per frame, in the cycle after the stop-bit sample. The error flags keep their values for that frame until the next start edge clears them.
- R12: The receive and transmit engines are independent. Frames on both lines, whether simultaneous or staggered, are each decoded correctly, and both valid outputs may pulse in the same cycle.
- R13: A configuration change made during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clks_per_bit | input | 16 | Clock cycles per serial bit (at least 4) |
| cfg_data_bits | input | 4 | Data length, 5 to 9 |
| cfg_parity | input | 3 | Parity rule: 0 none, 1 odd, 2 even, 3 fixed 0, 4 fixed 1, 5-7 none |
| cfg_msb_first | input | 1 | 1 = first data bit is the most significant |
| rx_line | input | 1 | Monitored receive line |
| tx_line | input | 1 | Monitored transmit line |
| rx_data | output | 9 | Decoded word, receive line |
| rx_valid | output | 1 | One-cycle frame-complete pulse, receive line |
| rx_start_err | output | 1 | Start bit was high at centre, receive line |
| rx_parity_err | output | 1 | Parity mismatch, receive line |
| rx_stop_err | output | 1 | Stop bit was low at centre, receive line |
| tx_data | output | 9 | Decoded word, transmit line |
| tx_valid | output | 1 | One-cycle frame-complete pulse, transmit line |
| tx_start_err | output | 1 | Start bit was high at centre, transmit line |
| tx_parity_err | output | 1 | Parity mismatch, transmit line |
| tx_stop_err | output | 1 | Stop bit was low at centre, transmit line |

## Verification
Two functions can land in the same cycle: frame completion on the receive engine and frame completion on the transmit engine. The bench provokes this by starting frames with different data on both lines on the same clock edge. Both valid pulses then fall in one cycle, and each must pop its own expected word from its own queue with no cross-talk. A staggered pair, where one line's stop bit overlaps the other line's data bits, also shows that neither engine's timing disturbs the other.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

    localparam int CPB_W   = 16;
    localparam int WORD_W  = 9;
    localparam int NB_W    = 4;
    localparam int CNT_W   = CPB_W + 4;
    localparam int MIN_BITS = 5;
    localparam int NUM_CH  = 2;

    typedef enum logic [2:0] {
        PAR_NONE = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_EVEN = 3'd2,
        PAR_ZERO = 3'd3,
        PAR_ONE  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } chan_state_e;

    typedef struct packed {
        logic [CPB_W-1:0] cpb;
        logic [NB_W-1:0]  nbits;
        par_mode_e        par;
        logic             msb_first;
    } mon_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic              start_err;
        logic              par_err;
        logic              stop_err;
    } mon_res_t;

    function automatic par_mode_e decode_par(input logic [2:0] code);
        if (code > 3'd4)
            return PAR_NONE;
        return par_mode_e'(code);
    endfunction

    function automatic logic [NB_W-1:0] clamp_bits(input logic [NB_W-1:0] nb);
        if (nb < NB_W'(MIN_BITS))
            return NB_W'(MIN_BITS);
        if (nb > NB_W'(WORD_W))
            return NB_W'(WORD_W);
        return nb;
    endfunction

    function automatic logic parity_good(input par_mode_e mode, input logic pbit,
                                         input logic [WORD_W-1:0] word);
        logic odd_ones;
        odd_ones = (^word) ^ pbit;
        case (mode)
            PAR_ODD:  return odd_ones;
            PAR_EVEN: return !odd_ones;
            PAR_ZERO: return !pbit;
            PAR_ONE:  return pbit;
            default:  return 1'b1;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] w,
                                                   input logic b,
                                                   input logic [NB_W-1:0] nb,
                                                   input logic msb);
        logic [WORD_W-1:0] r;
        logic [WORD_W-1:0] wr;
        wr = w >> 1;
        r  = '0;
        if (msb) begin
            r = {w[WORD_W-2:0], b};
        end else begin
            for (int i = 0; i < WORD_W; i++) begin
                if (i == int'(nb) - 1)
                    r[i] = b;
                else if (i < int'(nb) - 1)
                    r[i] = wr[i];
                else
                    r[i] = 1'b0;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/uart_mon_sync.sv
module uart_mon_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/uart_mon_chan.sv
module uart_mon_chan
    import uart_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     line_s,
    input  mon_cfg_t cfg,
    output mon_res_t res
);
    chan_state_e       state_q;
    mon_cfg_t          cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  target_q;
    logic [NB_W-1:0]   bit_idx_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] data_q;
    logic              prev_q;
    logic              prev_ok_q;
    logic              valid_q;
    logic              start_err_q;
    logic              par_err_q;
    logic              stop_err_q;

    logic              fall_edge;
    logic              hit;

    assign fall_edge = prev_ok_q && prev_q && !line_s;
    assign hit       = (cnt_q == target_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cfg_q       <= '0;
            cnt_q       <= '0;
            target_q    <= '0;
            bit_idx_q   <= '0;
            word_q      <= '0;
            data_q      <= '0;
            prev_q      <= 1'b0;
            prev_ok_q   <= 1'b0;
            valid_q     <= 1'b0;
            start_err_q <= 1'b0;
            par_err_q   <= 1'b0;
            stop_err_q  <= 1'b0;
        end else begin
            prev_q    <= line_s;
            prev_ok_q <= 1'b1;
            valid_q   <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (fall_edge) begin
                    cfg_q       <= cfg;
                    cnt_q       <= CNT_W'(1);
                    target_q    <= CNT_W'(cfg.cpb >> 1);
                    bit_idx_q   <= '0;
                    word_q      <= '0;
                    start_err_q <= 1'b0;
                    par_err_q   <= 1'b0;
                    stop_err_q  <= 1'b0;
                    state_q     <= ST_START;
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (hit) begin
                    target_q <= target_q + CNT_W'(cfg_q.cpb);
                    case (state_q)
                        ST_START: begin
                            start_err_q <= line_s;
                            state_q     <= ST_DATA;
                        end
                        ST_DATA: begin
                            word_q <= shift_in(word_q, line_s, cfg_q.nbits, cfg_q.msb_first);
                            if (bit_idx_q == cfg_q.nbits - NB_W'(1)) begin
                                state_q <= (cfg_q.par == PAR_NONE) ? ST_STOP : ST_PAR;
                            end else begin
                                bit_idx_q <= bit_idx_q + NB_W'(1);
                            end
                        end
                        ST_PAR: begin
                            par_err_q <= !parity_good(cfg_q.par, line_s, word_q);
                            state_q   <= ST_STOP;
                        end
                        ST_STOP: begin
                            stop_err_q <= !line_s;
                            valid_q    <= 1'b1;
                            data_q     <= word_q;
                            state_q    <= ST_IDLE;
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    always_comb begin
        res.valid     = valid_q;
        res.data      = data_q;
        res.start_err = start_err_q;
        res.par_err   = par_err_q;
        res.stop_err  = stop_err_q;
    end
endmodule

// File: rtl/uart_mon_dual.sv
module uart_mon_dual
    import uart_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CPB_W-1:0]  cfg_clks_per_bit,
    input  logic [NB_W-1:0]   cfg_data_bits,
    input  logic [2:0]        cfg_parity,
    input  logic              cfg_msb_first,
    input  logic              rx_line,
    input  logic              tx_line,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_start_err,
    output logic              rx_parity_err,
    output logic              rx_stop_err,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              tx_start_err,
    output logic              tx_parity_err,
    output logic              tx_stop_err
);
    mon_cfg_t           cfg_dec;
    logic [NUM_CH-1:0]  line_raw;
    logic [NUM_CH-1:0]  line_sync;
    mon_res_t           res [NUM_CH];

    always_comb begin
        cfg_dec.cpb       = cfg_clks_per_bit;
        cfg_dec.nbits     = clamp_bits(cfg_data_bits);
        cfg_dec.par       = decode_par(cfg_parity);
        cfg_dec.msb_first = cfg_msb_first;
    end

    assign line_raw = {tx_line, rx_line};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        uart_mon_sync u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (line_raw[ch]),
            .dout (line_sync[ch])
        );
        uart_mon_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .line_s (line_sync[ch]),
            .cfg    (cfg_dec),
            .res    (res[ch])
        );
    end

    assign rx_data       = res[0].data;
    assign rx_valid      = res[0].valid;
    assign rx_start_err  = res[0].start_err;
    assign rx_parity_err = res[0].par_err;
    assign rx_stop_err   = res[0].stop_err;
    assign tx_data       = res[1].data;
    assign tx_valid      = res[1].valid;
    assign tx_start_err  = res[1].start_err;
    assign tx_parity_err = res[1].par_err;
    assign tx_stop_err   = res[1].stop_err;
endmodule

// File: rtl/uart_mon_chk.sv
module uart_mon_chk (
    input logic clk,
    input logic rst,
    input logic rx_valid,
    input logic rx_start_err,
    input logic rx_parity_err,
    input logic rx_stop_err,
    input logic tx_valid,
    input logic tx_start_err,
    input logic tx_parity_err,
    input logic tx_stop_err
);
    a_r11_rx_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
    a_r11_tx_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> !tx_valid);
    a_r10_rx_stop_err_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_stop_err) |-> rx_valid);
    a_r10_tx_stop_err_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_stop_err) |-> tx_valid);
    a_r9_rx_flags_settled: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ($stable(rx_start_err) && $stable(rx_parity_err)));
    a_r9_tx_flags_settled: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> ($stable(tx_start_err) && $stable(tx_parity_err)));
endmodule

bind uart_mon_dual uart_mon_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .rx_valid      (rx_valid),
    .rx_start_err  (rx_start_err),
    .rx_parity_err (rx_parity_err),
    .rx_stop_err   (rx_stop_err),
    .tx_valid      (tx_valid),
    .tx_start_err  (tx_start_err),
    .tx_parity_err (tx_parity_err),
    .tx_stop_err   (tx_stop_err)
);

// File: tb/sim_uart_mon_dual.sv
`timescale 1ns/1ps
module sim_uart_mon_dual;
    localparam int CPB = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_cpb = 16'(CPB);
    logic [3:0]  cfg_bits = 4'd8;
    logic [2:0]  cfg_par = 3'd0;
    logic        cfg_msb = 1'b0;
    logic        rx_l = 1'b1;
    logic        tx_l = 1'b1;
    logic [8:0]  rx_data, tx_data;
    logic        rx_valid, rx_start_err, rx_parity_err, rx_stop_err;
    logic        tx_valid, tx_start_err, tx_parity_err, tx_stop_err;

    int total = 0;
    int bad   = 0;
    int rx_seen = 0;
    int tx_seen = 0;
    int cycles = 0;
    bit finished = 0;

    typedef struct {
        logic [8:0] d;
        bit         se;
        bit         pe;
        bit         ste;
        string      tag;
    } exp_t;

    exp_t q_rx[$];
    exp_t q_tx[$];

    always #10 clk = ~clk;

    uart_mon_dual u0 (
        .clk(clk), .rst(rst),
        .cfg_clks_per_bit(cfg_cpb), .cfg_data_bits(cfg_bits),
        .cfg_parity(cfg_par), .cfg_msb_first(cfg_msb),
        .rx_line(rx_l), .tx_line(tx_l),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_start_err(rx_start_err),
        .rx_parity_err(rx_parity_err), .rx_stop_err(rx_stop_err),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_start_err(tx_start_err),
        .tx_parity_err(tx_parity_err), .tx_stop_err(tx_stop_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic set_line(input int ch, input logic v);
        if (ch == 0) rx_l = v; else tx_l = v;
    endtask

    task automatic hold(input int ch, input logic v, input int n);
        set_line(ch, v);
        repeat (n) @(negedge clk);
    endtask

    // Drives one frame using the configuration present at call time and
    // pushes the expected decode into the channel's scoreboard queue.
    task automatic send(input int ch, input logic [8:0] d, input bit bad_start,
                        input bit bad_par, input bit bad_stop, input string tag);
        int nb;
        int pc;
        bit msb;
        logic [8:0] dm;
        logic pbit;
        exp_t e;
        nb  = int'(cfg_bits);
        if (nb < 5) nb = 5;
        if (nb > 9) nb = 9;
        pc  = int'(cfg_par);
        if (pc > 4) pc = 0;
        msb = cfg_msb;
        dm  = d & 9'((1 << nb) - 1);
        case (pc)
            1: pbit = ~(^dm);
            2: pbit = ^dm;
            3: pbit = 1'b0;
            default: pbit = 1'b1;
        endcase
        if (bad_par) pbit = ~pbit;
        e.d = dm; e.se = bad_start; e.pe = (pc != 0) && bad_par; e.ste = bad_stop; e.tag = tag;
        if (ch == 0) q_rx.push_back(e); else q_tx.push_back(e);
        if (bad_start) begin
            hold(ch, 1'b0, 2);
            hold(ch, 1'b1, CPB - 2);
        end else begin
            hold(ch, 1'b0, CPB);
        end
        for (int i = 0; i < nb; i++)
            hold(ch, msb ? dm[nb-1-i] : dm[i], CPB);
        if (pc != 0)
            hold(ch, pbit, CPB);
        hold(ch, bad_stop ? 1'b0 : 1'b1, CPB);
        hold(ch, 1'b1, 2 * CPB);
    endtask

    task automatic judge(input int ch, input logic [8:0] d, input logic se,
                         input logic pe, input logic ste);
        exp_t e;
        if ((ch == 0 && q_rx.size() == 0) || (ch == 1 && q_tx.size() == 0)) begin
            check(1'b0, "R1", $sformatf("unexpected valid on channel %0d", ch), 1, 0);
            return;
        end
        e = (ch == 0) ? q_rx.pop_front() : q_tx.pop_front();
        check(d == e.d, e.tag, $sformatf("data ch%0d", ch), int'(d), int'(e.d));
        check(se == e.se, e.tag, $sformatf("start flag ch%0d", ch), int'(se), int'(e.se));
        check(pe == e.pe, e.tag, $sformatf("parity flag ch%0d", ch), int'(pe), int'(e.pe));
        check(ste == e.ste, e.tag, $sformatf("stop flag ch%0d", ch), int'(ste), int'(e.ste));
    endtask

    // Monitor: samples away from the active edge.
    logic rx_v_last = 1'b0;
    logic tx_v_last = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_v_last) check(!rx_valid, "R11", "rx valid wider than one cycle", int'(rx_valid), 0);
            if (tx_v_last) check(!tx_valid, "R11", "tx valid wider than one cycle", int'(tx_valid), 0);
            if (rx_valid) begin rx_seen++; judge(0, rx_data, rx_start_err, rx_parity_err, rx_stop_err); end
            if (tx_valid) begin tx_seen++; judge(1, tx_data, tx_start_err, tx_parity_err, tx_stop_err); end
            rx_v_last = rx_valid;
            tx_v_last = tx_valid;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            summary();
        end
    end

    task automatic set_cfg(input int nb, input int pc, input bit msb);
        cfg_bits = 4'(nb);
        cfg_par  = 3'(pc);
        cfg_msb  = msb;
    endtask

    initial begin
        rx_l = 1'b0;   // R1: line low through reset
        tx_l = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rx_valid == 0 && tx_valid == 0, "R2", "valid after reset", int'(rx_valid | tx_valid), 0);
        check(rx_data == 0 && tx_data == 0, "R2", "data after reset", int'(rx_data | tx_data), 0);
        check({rx_start_err, rx_parity_err, rx_stop_err, tx_start_err, tx_parity_err, tx_stop_err} == 0,
              "R2", "flags after reset",
              int'({rx_start_err, rx_parity_err, rx_stop_err, tx_start_err, tx_parity_err, tx_stop_err}), 0);
        repeat (15 * CPB) @(negedge clk);
        check(rx_seen == 0, "R1", "frames from a line held low", rx_seen, 0);
        rx_l = 1'b1;
        repeat (2 * CPB) @(negedge clk);

        set_cfg(8, 0, 0);
        send(0, 9'h0A5, 0, 0, 0, "R2");
        send(1, 9'h03C, 0, 0, 0, "R2");
        set_cfg(7, 0, 0);
        send(0, 9'h05B, 0, 0, 0, "R7");
        set_cfg(8, 0, 1);
        send(0, 9'h0A5, 0, 0, 0, "R4");
        send(1, 9'h01E, 0, 0, 0, "R4");
        set_cfg(5, 0, 0);
        send(0, 9'h013, 0, 0, 0, "R3");
        set_cfg(9, 0, 0);
        send(1, 9'h1A7, 0, 0, 0, "R3");
        set_cfg(9, 0, 1);
        send(0, 9'h143, 0, 0, 0, "R3");
        set_cfg(3, 0, 0);
        send(0, 9'h0F6, 0, 0, 0, "R3");   // clamps to 5 bits: 0x16
        set_cfg(8, 1, 0);
        send(0, 9'h0B3, 0, 0, 0, "R5");
        send(0, 9'h0B3, 0, 1, 0, "R5");
        set_cfg(8, 2, 0);
        send(1, 9'h0B3, 0, 0, 0, "R5");
        send(1, 9'h071, 0, 1, 0, "R5");
        set_cfg(6, 3, 0);
        send(0, 9'h02D, 0, 0, 0, "R6");
        send(0, 9'h02D, 0, 1, 0, "R6");
        set_cfg(6, 4, 1);
        send(1, 9'h02D, 0, 0, 0, "R6");
        send(1, 9'h02D, 0, 1, 0, "R6");
        set_cfg(8, 6, 0);
        send(0, 9'h0C9, 0, 0, 0, "R8");
        set_cfg(8, 7, 0);
        send(1, 9'h037, 0, 0, 0, "R8");
        set_cfg(8, 1, 0);
        send(0, 9'h06E, 1, 0, 0, "R9");
        set_cfg(8, 0, 0);
        send(1, 9'h081, 0, 0, 1, "R10");
        fork
            send(1, 9'h042, 0, 0, 0, "R11");
            begin
                repeat (CPB) @(negedge clk);
                check(tx_stop_err == 0, "R11", "stop flag cleared by next start edge", int'(tx_stop_err), 0);
            end
        join
        set_cfg(8, 2, 0);
        fork
            send(0, 9'h0D4, 0, 0, 0, "R12");
            send(1, 9'h02B, 0, 1, 0, "R12");
        join
        fork
            send(0, 9'h119, 0, 0, 0, "R12");
            begin
                repeat (6 * CPB + 3) @(negedge clk);
                send(1, 9'h0E7, 0, 0, 0, "R12");
            end
        join
        set_cfg(8, 0, 0);
        fork
            send(0, 9'h0A6, 0, 0, 0, "R13");
            begin
                repeat (3 * CPB) @(negedge clk);
                set_cfg(5, 1, 1);
            end
        join
        repeat (4 * CPB) @(negedge clk);
        check(q_rx.size() == 0, "R12", "rx frames left unreported", q_rx.size(), 0);
        check(q_tx.size() == 0, "R12", "tx frames left unreported", q_tx.size(), 0);
        summary();
    end
endmodule